// File: doc/BRIEF.md
# Burst-Aligned DMA Transfer Scheduler

This block plans one memory-to-memory move through a circular staging buffer of `k` 32-byte bursts. Given a source address, a destination address, a byte count and the staging geometry, it emits read and write commands on a single valid/ready command port. Each command carries a bus address, a byte size, a burst flag and the staging-buffer offset that the data path should use. Bus interfaces, data storage, descriptor fetching and interrupts are outside the block.

A move runs in three stages. The head stage reads enough source bytes to reach a source burst boundary plus one steady-state chunk. It then writes enough to bring the destination to a burst boundary, so that both sides are aligned. The run stage repeats rounds of one chunk, `(k-1)*32` bytes: the chunk is read in source-unit commands and then written in destination-unit commands, and every command is an aligned full-burst multiple. The tail stage reads what is left of the source and then writes out everything still held in the buffer. A one-cycle `done_o` pulse closes the move.

Top module: `dma_burst_sched`

## Requirements
- R1: A start with `buf_bursts_i` below 2 or above `MAX_BURSTS` is rejected. So is a start where either unit is 0 or larger than `k-1`, or where neither unit equals `k-1`. A rejected start issues no command, and `done_o` and `cfg_err_o` are both high in the cycle after the start. This check comes before the zero-count check.
- R2: A valid start with a byte count of 0 issues no command. It raises `done_o` in the cycle after the start, with `cfg_err_o` low.
- R3: Staging occupancy never exceeds `k*32` bytes. A write command never asks for more bytes than are buffered.
- R4: The first command is one non-burst read at the source address. Its size is the smaller of the count and `ds + (k-1)*32`, where `ds = (32 - src mod 32) mod 32`.
- R5: If source bytes remain after the head read, a non-burst head write follows at the destination. With `dd` defined like `ds` for the destination, its size is `dd + (k-1)*32` when `dd <= ds`, and `dd + (k-2)*32` otherwise.
- R6: The burst flag (`cmd_burst_o=1`) marks run-stage commands only. Every run-stage command has an address and a size that are multiples of 32. Its size is the smaller of the unit times 32 and the bytes left in the current chunk.
- R7: A run round of one chunk read followed by one chunk write starts whenever the unread source bytes exceed `(k-1)*32`.
- R8: The tail issues one non-burst read of all remaining source bytes, if there are any, and then one non-burst write of all buffered bytes. Reads cover the source contiguously, writes cover the destination contiguously, and the bytes written total exactly the count.
- R9: `cmd_buf_o` is the fill offset on reads and the drain offset on writes. Both offsets start at 0 for each move and advance by the command size modulo `k*32`.
- R10: While `cmd_valid_o` is high and `cmd_ready_i` is low, the command holds unchanged.
- R11: `done_o` pulses for one cycle, in the cycle after the last write is accepted. A start asserted while a move is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a move; sampled only when idle |
| src_addr_i | input | ADDR_W | Source byte address |
| dst_addr_i | input | ADDR_W | Destination byte address |
| byte_cnt_i | input | CNT_W | Bytes to move |
| buf_bursts_i | input | KW | Staging buffer size `k` in bursts |
| src_unit_i | input | KW | Run-stage read size in bursts |
| dst_unit_i | input | KW | Run-stage write size in bursts |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted when high with valid |
| cmd_wr_o | output | 1 | 1 = write to destination, 0 = read from source |
| cmd_addr_o | output | ADDR_W | Bus byte address |
| cmd_size_o | output | SZ_W | Bytes in this command |
| cmd_burst_o | output | 1 | Run-stage aligned burst command |
| cmd_buf_o | output | PTR_W | Staging buffer byte offset |
| done_o | output | 1 | One-cycle end-of-move pulse |
| cfg_err_o | output | 1 | High with `done_o` when the start was rejected |

## Verification
Directed moves cover the relative alignments that choose the head-write rule: both addresses aligned, source further from its boundary than the destination, and the reverse. Counts are placed just below, at and just above the head size and one chunk beyond it, so that head-only, tail-only and multi-round cases can be told apart. Random moves vary `k` from 2 to 8, the unit pair, the addresses and the count under random back-pressure. A byte-array model copies data through a staging array at the offsets the design reports, which exposes any wrong size, address or offset. Rejected configurations, zero counts and a start asserted in mid-move check that nothing is issued when it should not be.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int unsigned BURST_BYTES = 32;
  localparam int unsigned BURST_SH    = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD_RD,
    ST_HEAD_WR,
    ST_RUN_RD,
    ST_RUN_WR,
    ST_TAIL_RD,
    ST_TAIL_WR,
    ST_DONE
  } sched_st_e;
endpackage

// File: rtl/dma_align_calc.sv
module dma_align_calc #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned KW    = 4,
  parameter int unsigned SZ_W  = 9
) (
  input  logic [4:0]       src_lo_i,
  input  logic [4:0]       dst_lo_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [KW-1:0]    bursts_i,
  output logic [SZ_W-1:0]  chunk_o,
  output logic [SZ_W-1:0]  head_rd_o,
  output logic [SZ_W-1:0]  head_wr_o
);
  logic [4:0]       ds, dd;
  logic [CNT_W-1:0] lim;

  always_comb begin
    ds        = 5'(5'd0 - src_lo_i);  // distance to next boundary, 0..31
    dd        = 5'(5'd0 - dst_lo_i);
    chunk_o   = (SZ_W'(bursts_i) - SZ_W'(1)) << 5;
    lim       = CNT_W'(ds) + CNT_W'(chunk_o);
    head_rd_o = (cnt_i < lim) ? SZ_W'(cnt_i) : SZ_W'(lim);
    head_wr_o = (dd <= ds) ? SZ_W'(dd) + chunk_o
                           : SZ_W'(dd) + chunk_o - SZ_W'(32);
  end
endmodule

// File: rtl/dma_ring_track.sv
module dma_ring_track #(
  parameter int unsigned PTR_W = 8,
  parameter int unsigned SZ_W  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [SZ_W-1:0]  cap_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [SZ_W-1:0]  size_i,
  output logic [PTR_W-1:0] fill_o,
  output logic [PTR_W-1:0] drain_o,
  output logic [SZ_W-1:0]  occ_o
);
  localparam int unsigned SUM_W = SZ_W + 1;

  logic [PTR_W-1:0] fill_q, drain_q, fill_nx, drain_nx;
  logic [SZ_W-1:0]  occ_q;
  logic [SUM_W-1:0] fsum, dsum;

  always_comb begin
    fsum     = SUM_W'(fill_q) + SUM_W'(size_i);
    dsum     = SUM_W'(drain_q) + SUM_W'(size_i);
    fill_nx  = (fsum >= SUM_W'(cap_i)) ? PTR_W'(fsum - SUM_W'(cap_i)) : PTR_W'(fsum);
    drain_nx = (dsum >= SUM_W'(cap_i)) ? PTR_W'(dsum - SUM_W'(cap_i)) : PTR_W'(dsum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q  <= '0;
      drain_q <= '0;
      occ_q   <= '0;
    end else if (clr_i) begin
      fill_q  <= '0;
      drain_q <= '0;
      occ_q   <= '0;
    end else if (push_i) begin
      fill_q  <= fill_nx;
      occ_q   <= occ_q + size_i;
    end else if (pop_i) begin
      drain_q <= drain_nx;
      occ_q   <= occ_q - size_i;
    end
  end

  assign fill_o  = fill_q;
  assign drain_o = drain_q;
  assign occ_o   = occ_q;

  p_fill_fits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (SUM_W'(occ_q) + SUM_W'(size_i)) <= SUM_W'(cap_i));
  p_drain_avail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> size_i <= occ_q);
  p_occ_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= cap_i);
endmodule

// File: rtl/dma_burst_sched.sv
module dma_burst_sched
  import dma_sched_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned MAX_BURSTS = 8,
  localparam int unsigned CAP_MAX   = MAX_BURSTS * BURST_BYTES,
  localparam int unsigned SZ_W      = $clog2(CAP_MAX + 1),
  localparam int unsigned PTR_W     = $clog2(CAP_MAX),
  localparam int unsigned KW        = $clog2(MAX_BURSTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic [KW-1:0]     buf_bursts_i,
  input  logic [KW-1:0]     src_unit_i,
  input  logic [KW-1:0]     dst_unit_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_wr_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [SZ_W-1:0]   cmd_size_o,
  output logic              cmd_burst_o,
  output logic [PTR_W-1:0]  cmd_buf_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  sched_st_e         state_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  rem_q, rem_nx;
  logic [SZ_W-1:0]   seg_q, chunk_q, hwr_q, cap_q;
  logic [KW-1:0]     su_q, du_q;
  logic              err_q;

  logic [SZ_W-1:0]   chunk_c, hrd_c, hwr_c, unit_c, occ, occ_nx;
  logic [PTR_W-1:0]  fill_ptr, drain_ptr;
  logic              hs, last, accept, bad_cfg;
  logic [KW-1:0]     km1;

  dma_align_calc #(.CNT_W(CNT_W), .KW(KW), .SZ_W(SZ_W)) u_align (
    .src_lo_i (src_addr_i[4:0]),
    .dst_lo_i (dst_addr_i[4:0]),
    .cnt_i    (byte_cnt_i),
    .bursts_i (buf_bursts_i),
    .chunk_o  (chunk_c),
    .head_rd_o(hrd_c),
    .head_wr_o(hwr_c)
  );

  dma_ring_track #(.PTR_W(PTR_W), .SZ_W(SZ_W)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .cap_i  (cap_q),
    .push_i (hs && !cmd_wr_o),
    .pop_i  (hs && cmd_wr_o),
    .size_i (cmd_size_o),
    .fill_o (fill_ptr),
    .drain_o(drain_ptr),
    .occ_o  (occ)
  );

  always_comb begin
    km1     = buf_bursts_i - KW'(1);
    bad_cfg = (buf_bursts_i < KW'(2)) || (buf_bursts_i > KW'(MAX_BURSTS)) ||
              (src_unit_i == '0) || (dst_unit_i == '0) ||
              (src_unit_i > km1) || (dst_unit_i > km1) ||
              ((src_unit_i != km1) && (dst_unit_i != km1));
    accept  = (state_q == ST_IDLE) && start_i;
  end

  always_comb begin
    cmd_valid_o = (state_q != ST_IDLE) && (state_q != ST_DONE);
    cmd_wr_o    = (state_q == ST_HEAD_WR) || (state_q == ST_RUN_WR) ||
                  (state_q == ST_TAIL_WR);
    cmd_burst_o = (state_q == ST_RUN_RD) || (state_q == ST_RUN_WR);
    case (state_q)
      ST_RUN_RD: unit_c = SZ_W'(su_q) << BURST_SH;
      ST_RUN_WR: unit_c = SZ_W'(du_q) << BURST_SH;
      default:   unit_c = seg_q;
    endcase
    cmd_size_o = (unit_c < seg_q) ? unit_c : seg_q;
    cmd_addr_o = cmd_wr_o ? dst_q : src_q;
    cmd_buf_o  = cmd_wr_o ? drain_ptr : fill_ptr;
    hs         = cmd_valid_o && cmd_ready_i;
    last       = (cmd_size_o == seg_q);
    occ_nx     = cmd_wr_o ? occ - cmd_size_o : occ + cmd_size_o;
    rem_nx     = cmd_wr_o ? rem_q : rem_q - CNT_W'(cmd_size_o);
    done_o     = (state_q == ST_DONE);
    cfg_err_o  = err_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      seg_q   <= '0;
      chunk_q <= '0;
      hwr_q   <= '0;
      cap_q   <= '0;
      su_q    <= '0;
      du_q    <= '0;
      err_q   <= 1'b0;
    end else if (accept) begin
      src_q   <= src_addr_i;
      dst_q   <= dst_addr_i;
      rem_q   <= byte_cnt_i;
      seg_q   <= hrd_c;
      chunk_q <= chunk_c;
      hwr_q   <= hwr_c;
      cap_q   <= SZ_W'(buf_bursts_i) << BURST_SH;
      su_q    <= src_unit_i;
      du_q    <= dst_unit_i;
      err_q   <= bad_cfg;
      state_q <= (bad_cfg || byte_cnt_i == '0) ? ST_DONE : ST_HEAD_RD;
    end else if (state_q == ST_DONE) begin
      err_q   <= 1'b0;
      state_q <= ST_IDLE;
    end else if (hs) begin
      if (cmd_wr_o) dst_q <= dst_q + ADDR_W'(cmd_size_o);
      else          src_q <= src_q + ADDR_W'(cmd_size_o);
      rem_q <= rem_nx;
      seg_q <= seg_q - cmd_size_o;
      if (last) begin
        case (state_q)
          ST_HEAD_RD: begin
            if (rem_nx == '0) begin
              state_q <= ST_TAIL_WR;
              seg_q   <= occ_nx;
            end else begin
              state_q <= ST_HEAD_WR;
              seg_q   <= hwr_q;
            end
          end
          ST_HEAD_WR, ST_RUN_WR: begin
            if (rem_q > CNT_W'(chunk_q)) begin
              state_q <= ST_RUN_RD;
              seg_q   <= chunk_q;
            end else begin
              state_q <= ST_TAIL_RD;
              seg_q   <= SZ_W'(rem_q);
            end
          end
          ST_RUN_RD: begin
            state_q <= ST_RUN_WR;
            seg_q   <= chunk_q;
          end
          ST_TAIL_RD: begin
            state_q <= ST_TAIL_WR;
            seg_q   <= occ_nx;
          end
          default: state_q <= ST_DONE;
        endcase
      end
    end
  end

  p_burst_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_burst_o) |->
      (cmd_addr_o[4:0] == 5'd0 && cmd_size_o[4:0] == 5'd0 && cmd_size_o != '0));
  p_hold_cmd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_size_o) &&
       $stable(cmd_wr_o) && $stable(cmd_buf_o)));
  p_done_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_valid_o);
  p_err_with_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> done_o);
  p_zero_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && byte_cnt_i == '0) |=> done_o);
endmodule

// File: tb/dma_burst_sched_tb_top.sv
module dma_burst_sched_tb_top;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int MAXB   = 8;
  localparam int SZ_W   = 9;
  localparam int PTR_W  = 8;
  localparam int KW     = 4;

  typedef struct {
    bit    wr;
    int    addr;
    int    size;
    bit    burst;
    int    bofs;
    string tag;
  } cmd_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] src_a = '0, dst_a = '0;
  logic [CNT_W-1:0]  cnt = '0;
  logic [KW-1:0]     kb = '0, su = '0, du = '0;
  logic              cmd_valid, cmd_ready = 1'b0, cmd_wr, cmd_burst, done, cfg_err;
  logic [ADDR_W-1:0] cmd_addr;
  logic [SZ_W-1:0]   cmd_size;
  logic [PTR_W-1:0]  cmd_buf;

  int   checks = 0, failures = 0, cyc = 0;
  cmd_t exp_q[$];
  byte  src_mem[4096];
  byte  dst_mem[4096];
  byte  tbuf[256];
  int   cur_cap = 64, occ_m = 0, last_hs_cyc = -1;
  bit   prev_stall = 0;
  logic [ADDR_W-1:0] p_addr;
  logic [SZ_W-1:0]   p_size;
  logic              p_wr;

  always #10 clk = ~clk;  // 50 MHz

  dma_burst_sched #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_BURSTS(MAXB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_addr_i(src_a), .dst_addr_i(dst_a), .byte_cnt_i(cnt),
    .buf_bursts_i(kb), .src_unit_i(su), .dst_unit_i(du),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_wr_o(cmd_wr),
    .cmd_addr_o(cmd_addr), .cmd_size_o(cmd_size), .cmd_burst_o(cmd_burst),
    .cmd_buf_o(cmd_buf), .done_o(done), .cfg_err_o(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Monitor: pops expected commands as the design's commands are accepted.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        chk(cmd_valid && cmd_addr == p_addr && cmd_size == p_size && cmd_wr == p_wr,
            "R10", "held command changed", int'(cmd_addr), int'(p_addr));
      cmd_ready = ($urandom_range(0, 3) != 0);
      if (cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R11", "unexpected command", int'(cmd_addr), -1);
        end else begin
          cmd_t e;
          e = exp_q.pop_front();
          chk(cmd_wr == e.wr && int'(cmd_addr) == e.addr && int'(cmd_size) == e.size &&
              cmd_burst == e.burst && int'(cmd_buf) == e.bofs,
              e.tag, $sformatf("cmd wr=%0d size=%0d burst=%0d buf=%0d exp wr=%0d size=%0d burst=%0d buf=%0d addr",
                               cmd_wr, cmd_size, cmd_burst, cmd_buf, e.wr, e.size, e.burst, e.bofs),
              int'(cmd_addr), e.addr);
          if (cmd_burst)
            chk(cmd_addr[4:0] == 0 && cmd_size[4:0] == 0, "R6", "burst misaligned",
                int'(cmd_addr), int'(cmd_addr) & ~31);
          if (!cmd_wr) begin
            for (int i = 0; i < int'(cmd_size); i++)
              tbuf[(int'(cmd_buf) + i) % cur_cap] = src_mem[(int'(cmd_addr) + i) & 4095];
            occ_m += int'(cmd_size);
            chk(occ_m <= cur_cap, "R3", "occupancy over capacity", occ_m, cur_cap);
          end else begin
            for (int i = 0; i < int'(cmd_size); i++)
              dst_mem[(int'(cmd_addr) + i) & 4095] = tbuf[(int'(cmd_buf) + i) % cur_cap];
            chk(int'(cmd_size) <= occ_m, "R3", "write exceeds buffered", int'(cmd_size), occ_m);
            occ_m -= int'(cmd_size);
            last_hs_cyc = cyc;
          end
        end
      end
      prev_stall = cmd_valid && !cmd_ready;
      p_addr = cmd_addr;
      p_size = cmd_size;
      p_wr   = cmd_wr;
    end
  end

  function automatic void push_cmd(bit wr, int addr, int size, bit burst, int bofs, string tag);
    cmd_t c;
    c.wr = wr; c.addr = addr; c.size = size; c.burst = burst; c.bofs = bofs; c.tag = tag;
    exp_q.push_back(c);
  endfunction

  function automatic int dist32(int a);
    return (32 - (a % 32)) % 32;
  endfunction

  function automatic bit cfg_bad(int k, int a, int b);
    return (k < 2) || (k > MAXB) || (a == 0) || (b == 0) || (a > k - 1) || (b > k - 1) ||
           (a != k - 1 && b != k - 1);
  endfunction

  // Driver-side model: expected command list built from the requirements.
  function automatic void build_expect(int s, int d, int n, int k, int a, int b);
    int ss, cap, ds, dd, rem, occ, fp, dp, sa, da, sz, left;
    if (cfg_bad(k, a, b) || n == 0) return;
    ss = (k - 1) * 32; cap = k * 32;
    ds = dist32(s); dd = dist32(d);
    rem = n; occ = 0; fp = 0; dp = 0; sa = s; da = d;
    sz = (n < ds + ss) ? n : ds + ss;                        // R4
    push_cmd(0, sa, sz, 0, fp, "R4");
    sa += sz; rem -= sz; occ += sz; fp = (fp + sz) % cap;
    if (rem == 0) begin
      push_cmd(1, da, occ, 0, dp, "R8");
      return;
    end
    sz = (dd <= ds) ? dd + ss : dd + ss - 32;                // R5
    push_cmd(1, da, sz, 0, dp, "R5");
    da += sz; occ -= sz; dp = (dp + sz) % cap;
    while (rem > ss) begin                                   // R7
      left = ss;
      while (left > 0) begin
        sz = (a * 32 < left) ? a * 32 : left;
        push_cmd(0, sa, sz, 1, fp, "R6");
        sa += sz; rem -= sz; occ += sz; left -= sz; fp = (fp + sz) % cap;
      end
      left = ss;
      while (left > 0) begin
        sz = (b * 32 < left) ? b * 32 : left;
        push_cmd(1, da, sz, 1, dp, "R7");
        da += sz; occ -= sz; left -= sz; dp = (dp + sz) % cap;
      end
    end
    push_cmd(0, sa, rem, 0, fp, "R8");
    occ += rem;
    push_cmd(1, da, occ, 0, (dp) % cap, "R9");
  endfunction

  task automatic run_xfer(int s, int d, int n, int k, int a, int b, bit poke);
    int  st_c, waited;
    bit  bad, none;
    bad  = cfg_bad(k, a, b);
    none = bad || (n == 0);
    cur_cap = (k >= 2 && k <= MAXB) ? k * 32 : 64;
    occ_m = 0;
    last_hs_cyc = -1;
    for (int i = 0; i < 4096; i++) dst_mem[i] = 8'hEE;
    build_expect(s, d, n, k, a, b);
    @(negedge clk); #1;
    src_a = ADDR_W'(s); dst_a = ADDR_W'(d); cnt = CNT_W'(n);
    kb = KW'(k); su = KW'(a); du = KW'(b);
    start = 1'b1;
    st_c = cyc;
    @(negedge clk); #1;
    start = 1'b0;
    waited = 0;
    while (!done && waited < 20000) begin
      if (poke && waited == 3) begin
        start = 1'b1; cnt = '0; src_a = '0;   // R11: ignored while busy
      end else begin
        start = 1'b0;
      end
      @(negedge clk); #1;
      waited++;
    end
    start = 1'b0;
    if (none) begin
      chk(done && cyc == st_c + 1, bad ? "R1" : "R2", "done cycle", cyc, st_c + 1);
      chk(cfg_err == bad, bad ? "R1" : "R2", "cfg_err", int'(cfg_err), int'(bad));
      chk(last_hs_cyc == -1, bad ? "R1" : "R2", "commands issued", last_hs_cyc, -1);
    end else begin
      chk(done && cyc == last_hs_cyc + 1, "R11", "done after last write", cyc, last_hs_cyc + 1);
      chk(!cfg_err, "R11", "cfg_err on good move", int'(cfg_err), 0);
      chk(exp_q.size() == 0, "R8", "commands missing", exp_q.size(), 0);
      chk(occ_m == 0, "R8", "bytes left buffered", occ_m, 0);
      begin
        int bad_i;
        bad_i = -1;
        for (int i = 0; i < n; i++)
          if (dst_mem[(d + i) & 4095] != src_mem[(s + i) & 4095] && bad_i < 0) bad_i = i;
        chk(bad_i < 0, "R8", "data copy mismatch at byte", bad_i, -1);
      end
    end
    exp_q.delete();
    @(negedge clk); #1;
    chk(!done, "R11", "done longer than one cycle", int'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) src_mem[i] = byte'($urandom);
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !done && !cfg_err, "R11", "reset state", int'(cmd_valid), 0);
    rst_n = 1'b1;
    // Head rule variants: aligned, ds>dd, dd>ds
    run_xfer(64, 128, 300, 4, 3, 1, 0);      // R5 both aligned
    run_xfer(70, 200, 500, 4, 3, 2, 0);      // R5 ds>dd
    run_xfer(90, 133, 500, 4, 1, 3, 0);      // R5 dd>ds
    run_xfer(95, 400, 10, 3, 2, 2, 0);       // R4 count below head size
    run_xfer(65, 500, 31 + 64, 3, 2, 1, 0);  // R4 count equals head size
    run_xfer(65, 500, 31 + 64 + 1, 3, 2, 1, 0);
    run_xfer(65, 500, 31 + 64 + 64, 3, 1, 2, 0);   // R7 exactly one chunk more
    run_xfer(65, 500, 31 + 64 + 65, 3, 1, 2, 0);   // R7 one round then tail
    run_xfer(3, 901, 777, 2, 1, 1, 0);       // k=2
    run_xfer(17, 33, 1000, 8, 7, 3, 1);      // R11 start while busy
    run_xfer(100, 100, 0, 4, 3, 3, 0);       // R2
    run_xfer(100, 100, 50, 1, 1, 1, 0);      // R1 k<2
    run_xfer(100, 100, 50, 9, 8, 8, 0);      // R1 k>max
    run_xfer(100, 100, 50, 4, 2, 2, 0);      // R1 neither unit equals k-1
    run_xfer(100, 100, 0, 4, 0, 3, 0);       // R1 before R2
    for (int t = 0; t < 40; t++) begin
      int k, a, b;
      k = $urandom_range(2, MAXB);
      a = k - 1;
      b = $urandom_range(1, k - 1);
      if ($urandom_range(0, 1) != 0) begin
        int tmp;
        tmp = a; a = b; b = tmp;
      end
      run_xfer($urandom_range(0, 1023), $urandom_range(0, 1023),
               $urandom_range(1, 1400), k, a, b, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule